// File: doc/BRIEF.md
# DMA Request/Acknowledge Endpoint Bridge

This block connects an external single-transfer DMA controller to the endpoint buffers of a USB device function. There are up to five data endpoints. Each one is set independently to CPU or DMA servicing and to IN or OUT direction. When a DMA-mode endpoint's buffer is ready, the bridge raises a request. For OUT, ready means data is waiting to be read. For IN, it means there is room to write. If several endpoints are ready, the one with the lowest index wins, and that choice is latched until the acknowledge is released. The acknowledge line acts as both chip select and data-port address. Read and write strobes inside the acknowledge window move exactly one 8-bit or 16-bit word, as a pop from or a push into the latched endpoint's buffer.

The bridge also raises per-endpoint interrupt pulses for DMA-mode endpoints:
- A not-ready pulse when the host meets a buffer that is not ready.
- An empty pulse when an IN buffer runs empty.
- A ready pulse for OUT endpoints only, and only after a short packet has arrived and its data has been fully drained.

A length register captures the byte count of the short packet. In continuous receive mode it instead captures the bytes received in full packets before the short one.

The packet report from the serial engine is a one-cycle valid strobe with no ready. The bridge accepts it in every cycle, so there is no back-pressure. The buffer side is also strobe based: a pop or push is issued only while the latched buffer has signalled ready, so the buffer never needs to stall it.

Top module: `dma_ep_bridge`

## Requirements
- R1: After reset, dreq is 0, all interrupt outputs are 0 and dma_len is 0.
- R2: In IDLE, dreq rises one clock after at least one endpoint has both ep_dma_mode and buf_ready set. dma_ep gives the lowest such index (bit i is endpoint i). Endpoints in CPU mode are never requested.
- R3: dreq falls one clock after it is sampled high together with dack. dma_ep holds its value from the rise of dreq until dack has fallen.
- R4: Each request moves exactly one word: a single one-cycle buf_pop or buf_push pulse, however long rd or wr is held.
- R5: For OUT endpoints (ep_dir_in bit 0), rd under dack pops, and dma_rdata shows buf_rdata. For IN endpoints (bit 1), wr under dack pushes dma_wdata onto buf_wdata. When wide_word is 0, bits 15:8 are forced to 0.
- R6: dreq stays low in the clock after dack is seen low. It may rise again after that, and only if a buffer is ready.
- R7: irq_nrdy[i] pulses one clock after nak_evt[i] when endpoint i is in DMA mode, and stays 0 for CPU-mode endpoints.
- R8: irq_empty[i] pulses one clock after buf_empty[i] rises, for DMA-mode IN endpoints only.
- R9: irq_ready never fires for IN endpoints. For an OUT DMA endpoint it pulses once, in the clock after a recorded short packet meets buf_ready low.
- R10: With cont_rx at 0, a short packet (pkt_short 1) on a DMA-mode OUT endpoint loads pkt_len into dma_len one clock later. Packets on IN or CPU-mode endpoints leave dma_len unchanged.
- R11: With cont_rx at 1, full packets on DMA-mode OUT endpoints are summed. A short packet then loads that sum into dma_len and clears it.
- R12: A strobe whose direction does not match the endpoint (rd to IN, wr to OUT) causes no pop or push and does not use up the request's one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ep_dma_mode | input | NUM_EP | 1 = endpoint serviced by DMA |
| ep_dir_in | input | NUM_EP | 1 = IN (device to host), 0 = OUT |
| buf_ready | input | NUM_EP | Buffer readable (OUT) or writable (IN) |
| buf_empty | input | NUM_EP | Buffer holds no data |
| nak_evt | input | NUM_EP | Host met a not-ready buffer (pulse) |
| wide_word | input | 1 | 1 = 16-bit words, 0 = 8-bit |
| dack | input | 1 | DMA acknowledge, chip select and port address |
| rd | input | 1 | DMA read strobe |
| wr | input | 1 | DMA write strobe |
| dma_wdata | input | DATA_W | Write data from the DMA controller |
| dma_rdata | output | DATA_W | Read data to the DMA controller |
| dreq | output | 1 | DMA request |
| dma_ep | output | EPW | Latched endpoint index |
| buf_pop | output | 1 | Take one word from the OUT buffer |
| buf_push | output | 1 | Put one word into the IN buffer |
| buf_wdata | output | DATA_W | Word for the IN buffer |
| buf_rdata | input | DATA_W | Head word of the OUT buffer |
| pkt_valid | input | 1 | Packet received strobe |
| pkt_ep | input | EPW | Endpoint of the received packet |
| pkt_len | input | LEN_W | Byte count of the received packet |
| pkt_short | input | 1 | Packet shorter than maximum size |
| cont_rx | input | 1 | Continuous receive mode |
| irq_ready | output | NUM_EP | Buffer-ready interrupt pulses |
| irq_nrdy | output | NUM_EP | Buffer-not-ready interrupt pulses |
| irq_empty | output | NUM_EP | Buffer-empty interrupt pulses |
| dma_len | output | LEN_W | Short-packet length register |

## Verification
Two events can land in the same clock: the DMA pop of a word from an OUT endpoint, and the arrival of a short packet on that same endpoint. The bench provokes this by pulsing the packet strobe in the same cycle as the read strobe under acknowledge. It then judges three things. The scoreboard must see exactly one pop. dma_len must load the short length on the next clock. irq_ready must stay quiet until the bench drops that endpoint's buf_ready, and must then pulse exactly one clock later.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2,
    ST_GAP  = 2'd3
  } dmab_st_e;
endpackage

// File: rtl/dmab_arbiter.sv
module dmab_arbiter #(
  parameter int NUM_EP = 5,
  parameter int EPW    = 3
) (
  input  logic [NUM_EP-1:0] cand,
  output logic              any,
  output logic [EPW-1:0]    idx
);
  always_comb begin
    any = |cand;
    idx = '0;
    for (int i = NUM_EP - 1; i >= 0; i--) begin
      if (cand[i]) idx = EPW'(i);
    end
  end
endmodule

// File: rtl/dmab_xfer.sv
module dmab_xfer
  import dmab_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int DATA_W = 16,
  parameter int EPW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_any,
  input  logic [EPW-1:0]    cand_idx,
  input  logic [NUM_EP-1:0] ep_dir_in,
  input  logic              dack,
  input  logic              rd,
  input  logic              wr,
  input  logic              wide_word,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic [DATA_W-1:0] dma_rdata,
  output logic              dreq,
  output logic [EPW-1:0]    dma_ep,
  output logic              buf_pop,
  output logic              buf_push,
  output logic [DATA_W-1:0] buf_wdata
);
  localparam int HI_W = DATA_W - 8;

  dmab_st_e       st;
  logic [EPW-1:0] sel;
  logic           done;
  logic           win;
  logic           sel_in;

  assign sel_in = ep_dir_in[sel];
  assign win    = (st == ST_REQ || st == ST_ACK) && dack && !done;

  assign buf_pop  = win && rd && !sel_in;
  assign buf_push = win && wr && sel_in;
  assign dreq     = (st == ST_REQ);
  assign dma_ep   = sel;

  assign dma_rdata = wide_word ? buf_rdata : {{HI_W{1'b0}}, buf_rdata[7:0]};
  assign buf_wdata = wide_word ? dma_wdata : {{HI_W{1'b0}}, dma_wdata[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      sel  <= '0;
      done <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          done <= 1'b0;
          if (cand_any) begin
            sel <= cand_idx;
            st  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (buf_pop || buf_push) done <= 1'b1;
          if (dack) st <= ST_ACK;
        end
        ST_ACK: begin
          if (buf_pop || buf_push) done <= 1'b1;
          if (!dack) st <= ST_GAP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmab_irq.sv
module dmab_irq #(
  parameter int NUM_EP = 5,
  parameter int EPW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_dma_mode,
  input  logic [NUM_EP-1:0] ep_dir_in,
  input  logic [NUM_EP-1:0] buf_ready,
  input  logic [NUM_EP-1:0] buf_empty,
  input  logic [NUM_EP-1:0] nak_evt,
  input  logic              pkt_valid,
  input  logic [EPW-1:0]    pkt_ep,
  input  logic              pkt_short,
  output logic [NUM_EP-1:0] irq_ready,
  output logic [NUM_EP-1:0] irq_nrdy,
  output logic [NUM_EP-1:0] irq_empty
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic empty_q;
    logic pend;
    logic out_dma;
    logic short_hit;

    assign out_dma   = ep_dma_mode[i] && !ep_dir_in[i];
    assign short_hit = pkt_valid && pkt_short && (pkt_ep == EPW'(i)) && out_dma;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        empty_q      <= 1'b0;
        pend         <= 1'b0;
        irq_ready[i] <= 1'b0;
        irq_nrdy[i]  <= 1'b0;
        irq_empty[i] <= 1'b0;
      end else begin
        empty_q      <= buf_empty[i];
        irq_nrdy[i]  <= ep_dma_mode[i] && nak_evt[i];
        irq_empty[i] <= ep_dma_mode[i] && ep_dir_in[i] && buf_empty[i] && !empty_q;
        irq_ready[i] <= pend && out_dma && !buf_ready[i];
        pend         <= short_hit || (pend && out_dma && buf_ready[i]);
      end
    end
  end
endmodule

// File: rtl/dmab_len.sv
module dmab_len #(
  parameter int NUM_EP = 5,
  parameter int EPW    = 3,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_dma_mode,
  input  logic [NUM_EP-1:0] ep_dir_in,
  input  logic              pkt_valid,
  input  logic [EPW-1:0]    pkt_ep,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              pkt_short,
  input  logic              cont_rx,
  output logic [LEN_W-1:0]  dma_len
);
  localparam logic [EPW:0] EP_LIM = (EPW + 1)'(NUM_EP);

  logic [LEN_W-1:0] acc;
  logic             hit;

  assign hit = pkt_valid && ({1'b0, pkt_ep} < EP_LIM) &&
               ep_dma_mode[pkt_ep] && !ep_dir_in[pkt_ep];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      dma_len <= '0;
    end else if (hit) begin
      if (pkt_short) begin
        dma_len <= cont_rx ? acc : pkt_len;
        acc     <= '0;
      end else if (cont_rx) begin
        acc <= acc + pkt_len;
      end
    end
  end
endmodule

// File: rtl/dma_ep_bridge.sv
module dma_ep_bridge #(
  parameter int NUM_EP = 5,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 11,
  localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_dma_mode,
  input  logic [NUM_EP-1:0] ep_dir_in,
  input  logic [NUM_EP-1:0] buf_ready,
  input  logic [NUM_EP-1:0] buf_empty,
  input  logic [NUM_EP-1:0] nak_evt,
  input  logic              wide_word,
  input  logic              dack,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic [DATA_W-1:0] dma_rdata,
  output logic              dreq,
  output logic [EPW-1:0]    dma_ep,
  output logic              buf_pop,
  output logic              buf_push,
  output logic [DATA_W-1:0] buf_wdata,
  input  logic [DATA_W-1:0] buf_rdata,
  input  logic              pkt_valid,
  input  logic [EPW-1:0]    pkt_ep,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              pkt_short,
  input  logic              cont_rx,
  output logic [NUM_EP-1:0] irq_ready,
  output logic [NUM_EP-1:0] irq_nrdy,
  output logic [NUM_EP-1:0] irq_empty,
  output logic [LEN_W-1:0]  dma_len
);
  logic [NUM_EP-1:0] cand;
  logic              cand_any;
  logic [EPW-1:0]    cand_idx;

  assign cand = ep_dma_mode & buf_ready;

  dmab_arbiter #(.NUM_EP(NUM_EP), .EPW(EPW)) u_arb (
    .cand (cand),
    .any  (cand_any),
    .idx  (cand_idx)
  );

  dmab_xfer #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .EPW(EPW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand_any  (cand_any),
    .cand_idx  (cand_idx),
    .ep_dir_in (ep_dir_in),
    .dack      (dack),
    .rd        (rd),
    .wr        (wr),
    .wide_word (wide_word),
    .dma_wdata (dma_wdata),
    .buf_rdata (buf_rdata),
    .dma_rdata (dma_rdata),
    .dreq      (dreq),
    .dma_ep    (dma_ep),
    .buf_pop   (buf_pop),
    .buf_push  (buf_push),
    .buf_wdata (buf_wdata)
  );

  dmab_irq #(.NUM_EP(NUM_EP), .EPW(EPW)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ep_dma_mode (ep_dma_mode),
    .ep_dir_in   (ep_dir_in),
    .buf_ready   (buf_ready),
    .buf_empty   (buf_empty),
    .nak_evt     (nak_evt),
    .pkt_valid   (pkt_valid),
    .pkt_ep      (pkt_ep),
    .pkt_short   (pkt_short),
    .irq_ready   (irq_ready),
    .irq_nrdy    (irq_nrdy),
    .irq_empty   (irq_empty)
  );

  dmab_len #(.NUM_EP(NUM_EP), .EPW(EPW), .LEN_W(LEN_W)) u_len (
    .clk         (clk),
    .rst_n       (rst_n),
    .ep_dma_mode (ep_dma_mode),
    .ep_dir_in   (ep_dir_in),
    .pkt_valid   (pkt_valid),
    .pkt_ep      (pkt_ep),
    .pkt_len     (pkt_len),
    .pkt_short   (pkt_short),
    .cont_rx     (cont_rx),
    .dma_len     (dma_len)
  );
endmodule

// File: rtl/dma_ep_bridge_chk.sv
module dma_ep_bridge_chk #(
  parameter int NUM_EP = 5,
  parameter int EPW    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dreq,
  input logic              dack,
  input logic [EPW-1:0]    dma_ep,
  input logic              buf_pop,
  input logic              buf_push,
  input logic [NUM_EP-1:0] ep_dma_mode,
  input logic [NUM_EP-1:0] ep_dir_in,
  input logic [NUM_EP-1:0] irq_ready
);
  a_r3_dreq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && dack) |=> !dreq);

  a_r3_ep_held: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |=> $stable(dma_ep));

  a_r6_gap_after_dack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dack) |=> !dreq);

  a_r4_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_pop || buf_push) |=> !(buf_pop || buf_push));

  a_r2_dma_only: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> ep_dma_mode[dma_ep]);

  a_r9_no_in_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ready & ep_dir_in) == '0);
endmodule

bind dma_ep_bridge dma_ep_bridge_chk #(.NUM_EP(NUM_EP), .EPW(EPW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dreq        (dreq),
  .dack        (dack),
  .dma_ep      (dma_ep),
  .buf_pop     (buf_pop),
  .buf_push    (buf_push),
  .ep_dma_mode (ep_dma_mode),
  .ep_dir_in   (ep_dir_in),
  .irq_ready   (irq_ready)
);

// File: tb/test_dma_ep_bridge.sv
module test_dma_ep_bridge;
  localparam int NUM_EP = 5;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 11;
  localparam int EPW    = 3;

  typedef struct packed {
    logic              is_push;
    logic [EPW-1:0]    ep;
    logic [DATA_W-1:0] data;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_EP-1:0] ep_dma_mode = '0, ep_dir_in = '0, buf_ready = '0;
  logic [NUM_EP-1:0] buf_empty = '0, nak_evt = '0;
  logic              wide_word = 1'b0, dack = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [DATA_W-1:0] dma_wdata = '0, buf_rdata = '0;
  logic              pkt_valid = 1'b0, pkt_short = 1'b0, cont_rx = 1'b0;
  logic [EPW-1:0]    pkt_ep = '0;
  logic [LEN_W-1:0]  pkt_len = '0;
  logic [DATA_W-1:0] dma_rdata, buf_wdata;
  logic              dreq, buf_pop, buf_push;
  logic [EPW-1:0]    dma_ep;
  logic [NUM_EP-1:0] irq_ready, irq_nrdy, irq_empty;
  logic [LEN_W-1:0]  dma_len;

  int    n_run = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;
  item_t exp_q[$];

  always #2 clk = ~clk;

  dma_ep_bridge #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .LEN_W(LEN_W)) i_dma_ep_bridge (
    .clk(clk), .rst_n(rst_n), .ep_dma_mode(ep_dma_mode), .ep_dir_in(ep_dir_in),
    .buf_ready(buf_ready), .buf_empty(buf_empty), .nak_evt(nak_evt),
    .wide_word(wide_word), .dack(dack), .rd(rd), .wr(wr), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata), .dreq(dreq), .dma_ep(dma_ep), .buf_pop(buf_pop),
    .buf_push(buf_push), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .pkt_valid(pkt_valid), .pkt_ep(pkt_ep), .pkt_len(pkt_len), .pkt_short(pkt_short),
    .cont_rx(cont_rx), .irq_ready(irq_ready), .irq_nrdy(irq_nrdy),
    .irq_empty(irq_empty), .dma_len(dma_len)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_item(input logic is_push, input logic [EPW-1:0] ep,
                             input logic [DATA_W-1:0] data);
    item_t it;
    it.is_push = is_push;
    it.ep      = ep;
    it.data    = data;
    exp_q.push_back(it);
  endtask

  task automatic set_pkt(input logic v, input logic [EPW-1:0] ep,
                         input logic [LEN_W-1:0] len, input logic sh);
    pkt_valid = v; pkt_ep = ep; pkt_len = len; pkt_short = sh;
  endtask

  // Scoreboard monitor: every buffer strobe must match the queue head (R4, R5, R12)
  always @(posedge clk) begin
    if (rst_n && (buf_pop || buf_push)) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4: unexpected strobe pop=%0b push=%0b ep=%0d", buf_pop, buf_push, dma_ep);
      end else begin
        item_t e;
        item_t a;
        e = exp_q.pop_front();
        a.is_push = buf_push;
        a.ep      = dma_ep;
        a.data    = buf_push ? buf_wdata : dma_rdata;
        if (a !== e) begin
          n_fail++;
          $display("FAIL R5: strobe actual %0h expected %0h", a, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 dreq", {31'd0, dreq}, 32'd0);
    check("R1 irq", {17'd0, irq_ready, irq_nrdy, irq_empty}, 32'd0);
    check("R1 len", {21'd0, dma_len}, 32'd0);

    // endpoint 0 CPU mode, 1 DMA OUT, 2 DMA IN
    ep_dma_mode = 5'b00110;
    ep_dir_in   = 5'b00100;
    buf_ready   = 5'b00111;
    buf_rdata   = 16'hA5C3;
    wide_word   = 1'b0;
    @(negedge clk);
    check("R2 dreq up", {31'd0, dreq}, 32'd1);
    check("R2 lowest dma ep", {29'd0, dma_ep}, 32'd1);
    dack = 1'b1;
    @(negedge clk);
    check("R3 dreq drop", {31'd0, dreq}, 32'd0);
    // read with a short packet on the same endpoint in the same cycle
    rd = 1'b1;
    set_pkt(1'b1, 3'd1, 11'd7, 1'b1);
    expect_item(1'b0, 3'd1, 16'h00C3);
    #1;
    check("R5 narrow read", {16'd0, dma_rdata}, 32'h00C3);
    check("R5 pop", {31'd0, buf_pop}, 32'd1);
    @(negedge clk);
    set_pkt(1'b0, 3'd0, 11'd0, 1'b0);
    check("R10 short len", {21'd0, dma_len}, 32'd7);
    check("R9 wait drain", {27'd0, irq_ready}, 32'd0);
    check("R3 ep held", {29'd0, dma_ep}, 32'd1);
    buf_ready = 5'b00100;
    @(negedge clk);
    check("R9 ready after drain", {27'd0, irq_ready}, 32'b00010);
    check("R4 no second pop", {31'd0, buf_pop}, 32'd0);
    dack = 1'b0;
    rd   = 1'b0;
    @(negedge clk);
    check("R6 gap 1", {31'd0, dreq}, 32'd0);
    check("R9 single pulse", {27'd0, irq_ready}, 32'd0);
    @(negedge clk);
    check("R6 gap 2", {31'd0, dreq}, 32'd0);
    @(negedge clk);
    check("R6 rerequest", {31'd0, dreq}, 32'd1);
    check("R2 next ep", {29'd0, dma_ep}, 32'd2);
    dack      = 1'b1;
    wide_word = 1'b1;
    @(negedge clk);
    rd = 1'b1;
    #1;
    check("R12 rd to IN ignored", {31'd0, buf_pop}, 32'd0);
    @(negedge clk);
    rd        = 1'b0;
    wr        = 1'b1;
    dma_wdata = 16'h1234;
    expect_item(1'b1, 3'd2, 16'h1234);
    #1;
    check("R5 wide write", {16'd0, buf_wdata}, 32'h1234);
    check("R12 push after mismatch", {31'd0, buf_push}, 32'd1);
    @(negedge clk);
    wr        = 1'b0;
    dack      = 1'b0;
    buf_ready = '0;
    repeat (4) @(negedge clk);
    check("R2 no request when idle", {31'd0, dreq}, 32'd0);
    check("R4 queue drained", exp_q.size(), 32'd0);

    // interrupts
    nak_evt = 5'b00011;
    @(negedge clk);
    nak_evt = '0;
    check("R7 nrdy dma only", {27'd0, irq_nrdy}, 32'b00010);
    buf_empty = 5'b00111;
    @(negedge clk);
    check("R8 empty IN only", {27'd0, irq_empty}, 32'b00100);
    @(negedge clk);
    check("R8 empty pulse", {27'd0, irq_empty}, 32'd0);
    set_pkt(1'b1, 3'd2, 11'd9, 1'b1);
    @(negedge clk);
    set_pkt(1'b0, 3'd0, 11'd0, 1'b0);
    check("R10 IN ignored", {21'd0, dma_len}, 32'd7);
    @(negedge clk);
    check("R9 none for IN", {27'd0, irq_ready}, 32'd0);

    // continuous receive mode
    cont_rx = 1'b1;
    set_pkt(1'b1, 3'd1, 11'd64, 1'b0);
    @(negedge clk);
    set_pkt(1'b1, 3'd1, 11'd64, 1'b0);
    @(negedge clk);
    set_pkt(1'b1, 3'd0, 11'd64, 1'b0);
    @(negedge clk);
    set_pkt(1'b1, 3'd1, 11'd5, 1'b1);
    @(negedge clk);
    set_pkt(1'b0, 3'd0, 11'd0, 1'b0);
    check("R11 cont sum", {21'd0, dma_len}, 32'd128);
    @(negedge clk);
    check("R9 already drained", {27'd0, irq_ready}, 32'b00010);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule